// File: doc/BRIEF.md
# Enable-Framed Parallel-In Serial-Out Port Expander

This block takes an 11-bit word from a set of parallel inputs and sends it to a host controller one bit at a time. The serial link has three wires: an active-low select line, a serial clock and a serial data line. Both control lines come from the host and are not tied to the block's own clock. The block runs on an internal system clock. It passes each control line through a synchroniser and then looks for edges on it. The serial data pin is modelled as a data bit plus an output enable, which together stand for a tri-state driver.

When the select line falls, the block takes a snapshot of the whole input word and puts bit 0 on the data line straight away. Each later falling edge of the serial clock moves the line on to the next higher bit. If the host keeps clocking after the last bit, the block holds the line at 0 and raises an overrun flag until select goes high again. Any later falling edge of select starts a new frame with a new capture.

Top module: `pin_serializer`

## Requirements
- R1: While the reset input is low, `ser_oe`, `ser_out` and `ovr_flag` are all 0. After reset the shift count is 0 and no frame is open.
- R2: On a falling edge of `sel_n`, the block samples all bits of `par_in` in one clock cycle. The bits later sent on `ser_out` are exactly the bits of that snapshot.
- R3: Bit 0 of the snapshot appears on `ser_out`, with `ser_oe` at 1, in the same cycle that the output is enabled. No serial-clock edge is needed for this.
- R4: While `sel_n` stays low, each falling edge of `sck` moves `ser_out` to the next higher bit, from bit 1 through bit 10.
- R5: While `sel_n` is high, `ser_oe` is 0 and `ser_out` is held at 0. This 0 stands for high impedance.
- R6: The 11th falling `sck` edge of a frame, and every later one in that frame, drives `ser_out` to 0 and sets `ovr_flag` to 1. Both stay that way until `sel_n` rises.
- R7: Changes on `par_in` while `sel_n` is low have no effect on the bits sent in the current frame.
- R8: A rising edge of `sel_n` clears the shift count and the overrun flag. The next falling edge starts again from a fresh capture, beginning at bit 0.
- R9: A change on `sel_n` or `sck` that is sampled at rising clock edge k shows on the outputs right after rising edge k+2. With default parameters this is two synchroniser stages plus one register.
- R10: Falling `sck` edges while `sel_n` is high have no effect on the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low frame select from the host (asynchronous) |
| sck | input | 1 | Serial clock from the host (asynchronous); data advances on its falling edge |
| par_in | input | NBITS | Parallel input word |
| ser_out | output | 1 | Serial data bit |
| ser_oe | output | 1 | Output enable for the serial data driver |
| ovr_flag | output | 1 | High after too many serial clocks in one frame |

## Verification
The hardest condition to reach is the overrun. It needs eleven falling serial-clock edges inside one low period of select. Each clock phase must also last several system cycles so that every edge gets through the synchroniser before the next one arrives. The stimulus runs one frame with thirteen such spaced edges. It checks after each edge, then raises select and checks that the flag clears and that the next frame begins again from bit 0. A behavioural model delays each control line by the synchroniser latency and is compared with the outputs on every clock. Other frames cover a mid-frame change of the parallel word, a frame cut short after a few bits, and clock toggles while the block is not selected.

// File: rtl/pinser_pkg.sv
package pinser_pkg;

  // Synchronised view of one control line: level now and one cycle earlier
  typedef struct packed {
    logic now;
    logic prev;
  } line_t;

  function automatic logic fell(input line_t l);
    return l.prev & ~l.now;
  endfunction

  function automatic logic rose(input line_t l);
    return ~l.prev & l.now;
  endfunction

endpackage

// File: rtl/pinser_sync.sv
module pinser_sync
  import pinser_pkg::*;
#(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  async_i,
  output line_t line_o
);

  logic [STAGES-1:0] chain_q;
  logic              hist_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= async_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= RST_VAL;
    else        hist_q <= chain_q[STAGES-1];
  end

  assign line_o.now  = chain_q[STAGES-1];
  assign line_o.prev = hist_q;

endmodule

// File: rtl/pinser_ctrl.sv
module pinser_ctrl
  import pinser_pkg::*;
#(
  parameter int NBITS = 11,
  localparam int CNT_W = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  line_t            sel_l,
  input  line_t            sck_l,
  output logic             load,
  output logic             shift,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovr_q
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBITS - 1);

  logic             active;
  logic             at_last;
  logic             sck_fall;
  logic [CNT_W-1:0] cnt_d;
  logic             ovr_d;

  always_comb begin
    sck_fall = fell(sck_l);
    active   = ~sel_l.now & ~sel_l.prev;
    at_last  = (cnt_q == LAST);
    load     = fell(sel_l);
    shift    = active & sck_fall & ~at_last & ~ovr_q;
    cnt_d    = cnt_q;
    ovr_d    = ovr_q;
    if (load | rose(sel_l)) begin
      cnt_d = '0;
      ovr_d = 1'b0;
    end else if (shift) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else if (active & sck_fall & at_last) begin
      ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

endmodule

// File: rtl/pinser_shreg.sv
module pinser_shreg #(
  parameter int NBITS = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [NBITS-1:0] par_in,
  output logic             lsb_o
);

  logic [NBITS-1:0] sh_q;
  logic [NBITS-1:0] sh_d;
  logic             sh_en;

  always_comb begin
    sh_en = load | shift;
    if (load) sh_d = par_in;
    else      sh_d = {1'b0, sh_q[NBITS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign lsb_o = sh_q[0];

endmodule

// File: rtl/pin_serializer.sv
module pin_serializer
  import pinser_pkg::*;
#(
  parameter int NBITS       = 11,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             sck,
  input  logic [NBITS-1:0] par_in,
  output logic             ser_out,
  output logic             ser_oe,
  output logic             ovr_flag
);

  line_t            sel_l;
  line_t            sck_l;
  logic             load;
  logic             shift;
  logic [CNT_W-1:0] cnt;
  logic             ovr_q;
  logic             lsb;

  pinser_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
    .clk(clk), .rst_n(rst_n), .async_i(sel_n), .line_o(sel_l)
  );

  pinser_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .async_i(sck), .line_o(sck_l)
  );

  pinser_ctrl #(.NBITS(NBITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_l(sel_l), .sck_l(sck_l),
    .load(load), .shift(shift), .cnt_q(cnt), .ovr_q(ovr_q)
  );

  pinser_shreg #(.NBITS(NBITS)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
    .par_in(par_in), .lsb_o(lsb)
  );

  // The delayed select level changes on the same edge as the load
  assign ser_oe   = ~sel_l.prev;
  assign ser_out  = ser_oe & ~ovr_q & lsb;
  assign ovr_flag = ovr_q;

endmodule

// File: rtl/pinser_chk.sv
module pinser_chk #(
  parameter int NBITS = 11,
  localparam int CNT_W = $clog2(NBITS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_out,
  input logic             ser_oe,
  input logic             ovr_flag,
  input logic             load,
  input logic             shift,
  input logic [CNT_W-1:0] cnt
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_oe |-> !ser_out);  // R5

  AST_OVR_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag |-> !ser_out);  // R6

  AST_OVR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag |-> ser_oe);  // R6

  AST_FRESH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_oe) |-> !ovr_flag);  // R8

  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == '0) && !ovr_flag);  // R2

  AST_SHIFT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> cnt == $past(cnt) + CNT_W'(1));  // R4

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(NBITS - 1));  // R4

endmodule

bind pin_serializer pinser_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_out(ser_out), .ser_oe(ser_oe),
  .ovr_flag(ovr_flag), .load(load), .shift(shift), .cnt(cnt)
);

// File: tb/test_pin_serializer.sv
module test_pin_serializer;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 11;

  logic          clk;
  logic          rst_n;
  logic          sel_n;
  logic          sck;
  logic [NB-1:0] par_in;
  logic          ser_out;
  logic          ser_oe;
  logic          ovr_flag;

  int n_chk;
  int n_fail;
  bit done;

  pin_serializer i_pin_serializer (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .par_in(par_in),
    .ser_out(ser_out), .ser_oe(ser_oe), .ovr_flag(ovr_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural model: control lines seen through a 3-sample history
  bit          h_sel[3];
  bit          h_sck[3];
  bit [NB-1:0] m_word;
  int          m_idx;
  bit          m_ovr;
  bit          m_oe;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin h_sel[i] = 1'b1; h_sck[i] = 1'b1; end
      m_word = '0; m_idx = 0; m_ovr = 1'b0; m_oe = 1'b0;
    end else begin
      bit nsel, osel, nsck, osck;
      nsel = h_sel[1]; osel = h_sel[2];
      nsck = h_sck[1]; osck = h_sck[2];
      if (osel && !nsel) begin
        m_word = par_in; m_idx = 0; m_ovr = 1'b0;
      end else if (!osel && nsel) begin
        m_idx = 0; m_ovr = 1'b0;
      end else if (!osel && !nsel && osck && !nsck) begin
        if (m_idx == NB-1) m_ovr = 1'b1;
        else if (!m_ovr) m_idx++;
      end
      m_oe = !nsel;
      h_sel[2] = h_sel[1]; h_sel[1] = h_sel[0]; h_sel[0] = sel_n;
      h_sck[2] = h_sck[1]; h_sck[1] = h_sck[0]; h_sck[0] = sck;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_out;
      exp_out = m_oe && !m_ovr && m_word[m_idx];
      chk(ser_oe == m_oe, "R5", "model ser_oe", ser_oe, m_oe);    // also R9
      chk(ovr_flag == m_ovr, "R6", "model ovr_flag", ovr_flag, m_ovr);
      chk(ser_out == exp_out, "R4", "model ser_out", ser_out, exp_out);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [NB-1:0] word, input int nclk, input bit alter);
    logic [NB-1:0] rx;
    rx = '0;
    @(negedge clk);
    par_in = word;
    sel_n  = 1'b0;
    wait_n(2);
    chk(ser_oe == 1'b0, "R9", "oe two edges after select", ser_oe, 0);
    wait_n(1);
    chk(ser_oe == 1'b1, "R9", "oe three edges after select", ser_oe, 1);
    wait_n(1);
    for (int i = 0; i <= nclk; i++) begin
      if (i < NB) rx[i] = ser_out;
      if (i == 0) chk(ser_oe && ser_out == word[0], "R3", "bit0 before clock", ser_out, word[0]);
      if (i >= NB) begin
        chk(ser_out == 1'b0, "R6", "data after overrun", ser_out, 0);
        chk(ovr_flag == 1'b1, "R6", "overrun flag", ovr_flag, 1);
      end else begin
        chk(ovr_flag == 1'b0, "R6", "no early overrun", ovr_flag, 0);
      end
      if (i == nclk) break;
      sck = 1'b0;
      if (alter && i == 0) par_in = ~word;
      wait_n(4);
      sck = 1'b1;
      wait_n(4);
    end
    for (int b = 0; b < NB; b++) begin
      if (b <= nclk) begin
        if (alter) chk(rx[b] == word[b], "R7", "bit kept after input change", rx[b], word[b]);
        else       chk(rx[b] == word[b], "R2", "snapshot bit", rx[b], word[b]);
      end
    end
    sel_n = 1'b1;
    wait_n(4);
    chk(ser_oe == 1'b0 && ser_out == 1'b0, "R5", "idle after frame", {ser_oe, ser_out}, 0);
    chk(ovr_flag == 1'b0, "R8", "flag cleared on rise", ovr_flag, 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; sel_n = 1'b1; sck = 1'b1; par_in = '0;
    wait_n(3);
    chk(ser_oe == 1'b0, "R1", "reset ser_oe", ser_oe, 0);
    chk(ser_out == 1'b0, "R1", "reset ser_out", ser_out, 0);
    chk(ovr_flag == 1'b0, "R1", "reset ovr_flag", ovr_flag, 0);
    rst_n = 1'b1;
    wait_n(4);

    xfer(11'h5A3, 10, 1'b0);   // R4 full frame
    xfer(11'h7FF, 10, 1'b0);
    xfer(11'h001, 10, 1'b1);   // R7 input changes mid-frame
    xfer(11'h2AA, 13, 1'b0);   // R6 overrun
    xfer(11'h155, 4, 1'b0);    // R8 cut short
    xfer(11'h4C1, 10, 1'b0);   // R8 fresh restart from bit 0

    // R10: clock edges while not selected
    for (int k = 0; k < 5; k++) begin
      sck = 1'b0; wait_n(4); sck = 1'b1; wait_n(4);
    end
    chk(ser_oe == 1'b0, "R10", "no enable from clocks alone", ser_oe, 0);
    xfer(11'h3F0, 10, 1'b0);
    xfer(11'h000, 12, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule